// File: doc/BRIEF.md
# Bidirectional Peripheral Port Register

This block gives a processor byte-wide access to one seven-line peripheral port whose lines can each be turned into an input or an output. Four lines carry general data, and three carry handshake roles: a low-order, a middle and a high-order handshake line. The high-order line can also raise a level interrupt.

Two 8-bit registers sit behind a one-bit offset. The level register holds the value each output line drives, plus one spare bit. The direction register picks input or output for each line. Its top bit lets the high-order handshake input drive an active-low interrupt request.

Reading the level register returns a blend of two sources. Lines set as outputs, and the spare bit, return the stored value. Lines set as inputs return the pin level after a two-flop synchroniser. Pin inputs are never used unsynchronised.

Top module: `gport_regs`

## Requirements
- R1: After reset the level register holds 0x7F and the direction register holds 0x00. All output enables are low, `pin_out` is 0x7F and `hl_n` is 1.
- R2: A register changes only on a rising clock edge where `cs` and `we` are both 1. If either is 0, both registers keep their values.
- R3: `addr` = 0 selects the level register and `addr` = 1 selects the direction register. Reading the direction register returns all eight stored bits.
- R4: `pin_oe[i]` equals direction bit i for i = 0..6. A 1 makes the line an output. Bit 6 is the high-order handshake line, bit 5 the middle one, bit 4 the low-order one, and bits 3..0 are data lines 3..0.
- R5: `pin_out[i]` equals level register bit i for i = 0..6, and a 1 is a high level.
- R6: Level register bit 7 has no pin. A read returns the value last written to it, whatever the direction setting.
- R7: A level register read returns the stored bit for bit 7 and for every line whose direction bit is 1. Every other line returns its synchronised pin level.
- R8: A change on `pin_in` is not visible after the first rising edge. It becomes visible in readback and in `hl_n` after the second rising edge.
- R9: When direction bit 7 is 1, `hl_n` equals the synchronised level of `pin_in[6]`. When direction bit 7 is 0, `hl_n` is 1.
- R10: While `cs` is 0, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Register select |
| we | input | 1 | Write strobe, used together with `cs` |
| addr | input | 1 | Register offset: 0 = level, 1 = direction |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pin_in | input | 7 | Raw pin levels from the port |
| pin_oe | output | 7 | Per-line output enable; 0 leaves the line high-impedance |
| pin_out | output | 7 | Per-line driven level |
| hl_n | output | 1 | Active-low level interrupt request |

## Verification
Two functions can fall on the same edge. A direction write can switch a line from output to input on the very edge where the synchroniser delivers that line's new level. The bench changes the pin two edges ahead of the write, so both updates land together. Right after that edge, the readback must already show the new live level, not the stored bit and not the stale pin value. In the same way, `hl_n` is checked straight after the interrupt is enabled while the high-order line is already held low. It must go low on the write edge itself, with no extra synchroniser delay.

// File: rtl/gport_pkg.sv
`timescale 1ns/1ps
package gport_pkg;
    localparam int GP_PINS  = 7;
    localparam int GP_REG_W = GP_PINS + 1;
    localparam int GP_TH    = GP_PINS - 1;

    typedef enum logic {
        OFS_LEVEL = 1'b0,
        OFS_DIR   = 1'b1
    } gp_ofs_e;

    typedef struct packed {
        logic               spare;
        logic [GP_PINS-1:0] lvl;
    } gp_level_t;

    typedef struct packed {
        logic               irq_en;
        logic [GP_PINS-1:0] dir;
    } gp_dir_t;

    localparam gp_level_t GP_LEVEL_RST = '{spare: 1'b0, lvl: '1};
    localparam gp_dir_t   GP_DIR_RST   = '{irq_en: 1'b0, dir: '0};

    // Output lines and the spare bit come from the register, input lines from the pins.
    function automatic logic [GP_REG_W-1:0] gp_blend(gp_level_t stored, gp_dir_t d,
                                                    logic [GP_PINS-1:0] live);
        logic [GP_REG_W-1:0] keep;
        keep = {1'b1, d.dir};
        return (stored & keep) | ({1'b0, live} & ~keep);
    endfunction
endpackage

// File: rtl/gport_sync.sv
`timescale 1ns/1ps
module gport_sync #(
    parameter int             W       = 7,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

    if (STAGES >= 2) begin : g_chk
        // R8: the last stage takes the previous stage's value one edge later
        p_sync_chain_r8: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> q == $past(stg[STAGES-2]));
    end
endmodule

// File: rtl/gport_regfile.sv
`timescale 1ns/1ps
module gport_regfile
    import gport_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs,
    input  logic                we,
    input  gp_ofs_e             addr,
    input  logic [GP_REG_W-1:0] wdata,
    output gp_level_t           level_q,
    output gp_dir_t             dir_q
);
    logic wr_level, wr_dir;

    always_comb begin
        wr_level = cs && we && (addr == OFS_LEVEL);
        wr_dir   = cs && we && (addr == OFS_DIR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= GP_LEVEL_RST;
            dir_q   <= GP_DIR_RST;
        end else begin
            if (wr_level) level_q <= gp_level_t'(wdata);
            if (wr_dir)   dir_q   <= gp_dir_t'(wdata);
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(cs && we) |=> $stable(level_q) && $stable(dir_q));

    p_level_wr_r5: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr == OFS_LEVEL) |=> level_q == $past(wdata));

    p_dir_wr_r4: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr == OFS_DIR) |=> dir_q == $past(wdata));
endmodule

// File: rtl/gport_readmux.sv
`timescale 1ns/1ps
module gport_readmux
    import gport_pkg::*;
(
    input  logic                cs,
    input  gp_ofs_e             addr,
    input  gp_level_t           level_q,
    input  gp_dir_t             dir_q,
    input  logic [GP_PINS-1:0]  live,
    output logic [GP_REG_W-1:0] rdata,
    output logic                hl_n
);
    always_comb begin
        rdata = '0;
        if (cs) begin
            unique case (addr)
                OFS_LEVEL: rdata = gp_blend(level_q, dir_q, live);
                OFS_DIR:   rdata = dir_q;
            endcase
        end
        hl_n = dir_q.irq_en ? live[GP_TH] : 1'b1;
    end

    always_comb begin
        // R10: an unselected bus reads zero
        if (!cs) a_idle_read_r10: assert (rdata == '0);
    end
endmodule

// File: rtl/gport_regs.sv
`timescale 1ns/1ps
module gport_regs
    import gport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs,
    input  logic                we,
    input  logic                addr,
    input  logic [GP_REG_W-1:0] wdata,
    output logic [GP_REG_W-1:0] rdata,
    input  logic [GP_PINS-1:0]  pin_in,
    output logic [GP_PINS-1:0]  pin_oe,
    output logic [GP_PINS-1:0]  pin_out,
    output logic                hl_n
);
    gp_ofs_e            ofs;
    gp_level_t          level_q;
    gp_dir_t            dir_q;
    logic [GP_PINS-1:0] live;

    assign ofs = gp_ofs_e'(addr);

    gport_sync #(
        .W       (GP_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({GP_PINS{1'b1}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (live)
    );

    gport_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .we      (we),
        .addr    (ofs),
        .wdata   (wdata),
        .level_q (level_q),
        .dir_q   (dir_q)
    );

    gport_readmux u_rd (
        .cs      (cs),
        .addr    (ofs),
        .level_q (level_q),
        .dir_q   (dir_q),
        .live    (live),
        .rdata   (rdata),
        .hl_n    (hl_n)
    );

    // Lines whose direction bit is 0 are left undriven (high-impedance).
    assign pin_oe  = dir_q.dir;
    assign pin_out = level_q.lvl;

    p_oe_after_write_r4: assert property (@(posedge clk) disable iff (rst)
        (cs && we && !addr) |=> $stable(pin_oe));

    p_out_after_write_r5: assert property (@(posedge clk) disable iff (rst)
        (cs && we && !addr) |=> pin_out == $past(wdata[GP_PINS-1:0]));

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr && !wdata[GP_REG_W-1]) |=> hl_n);

    p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
        (dir_q.irq_en && !live[GP_TH]) |-> !hl_n);
endmodule

// File: tb/gport_regs_test.sv
`timescale 1ns/1ps
module gport_regs_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0;
    logic       we = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [6:0] pin_in = 7'h7F;
    logic [6:0] pin_oe;
    logic [6:0] pin_out;
    logic       hl_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    gport_regs uut (
        .clk (clk), .rst (rst), .cs (cs), .we (we), .addr (addr),
        .wdata (wdata), .rdata (rdata), .pin_in (pin_in),
        .pin_oe (pin_oe), .pin_out (pin_out), .hl_n (hl_n)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(logic a, logic [7:0] v);
        cs = 1'b1; we = 1'b1; addr = a; wdata = v;
        @(posedge clk);
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] v);
        cs = 1'b1; we = 1'b0; addr = a;
        #1;
        v = rdata;
        cs = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(1'b0, v); chk("R1 level after reset", v, 8'h7F);
        rd(1'b1, v); chk("R1 direction after reset", v, 8'h00);
        chk("R1 pin_oe after reset", {1'b0, pin_oe}, 8'h00);
        chk("R1 pin_out after reset", {1'b0, pin_out}, 8'h7F);
        chk("R1 hl_n after reset", {7'b0, hl_n}, 8'h01);
    endtask

    task automatic t_write_gate;
        logic [7:0] v;
        cs = 1'b0; we = 1'b1; addr = 1'b1; wdata = 8'hFF;
        tick(1);
        we = 1'b0;
        rd(1'b1, v); chk("R2 write without cs", v, 8'h00);
        chk("R2 pin_oe untouched", {1'b0, pin_oe}, 8'h00);
        cs = 1'b1; we = 1'b0; addr = 1'b0; wdata = 8'hFF;
        tick(1);
        cs = 1'b0;
        rd(1'b0, v); chk("R2 write without we", v, 8'h7F);
    endtask

    task automatic t_dir_levels;
        logic [7:0] v;
        wr(1'b1, 8'h55);
        rd(1'b1, v); chk("R3 direction readback", v, 8'h55);
        chk("R4 pin_oe mirrors direction", {1'b0, pin_oe}, 8'h55);
        wr(1'b0, 8'hAA);
        chk("R5 pin_out mirrors level", {1'b0, pin_out}, 8'h2A);
        rd(1'b0, v); chk("R6 spare bit set", v, 8'hAA);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk("R6 spare bit clear", v, 8'h2A);
    endtask

    task automatic t_merge;
        logic [7:0] v;
        wr(1'b1, 8'h0F);
        wr(1'b0, 8'h05);
        pin_in = 7'h3A;
        tick(3);
        rd(1'b0, v); chk("R7 blend with data lines out", v, 8'h35);
        wr(1'b0, 8'h85);
        rd(1'b0, v); chk("R7 blend with spare bit", v, 8'hB5);
        chk("R5 pin_out drives stored", {1'b0, pin_out}, 8'h05);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);
        pin_in = 7'h7F;
        tick(3);
        pin_in = 7'h12;
        tick(1);
        rd(1'b0, v); chk("R8 hidden after one edge", v, 8'h7F);
        tick(1);
        rd(1'b0, v); chk("R8 visible after two edges", v, 8'h12);
    endtask

    task automatic t_irq;
        wr(1'b1, 8'h80);
        chk("R9 enable with line already low", {7'b0, hl_n}, 8'h00);
        pin_in = 7'h52;
        tick(1);
        chk("R9 still low after one edge", {7'b0, hl_n}, 8'h00);
        tick(1);
        chk("R9 follows line high", {7'b0, hl_n}, 8'h01);
        pin_in = 7'h12;
        tick(2);
        chk("R9 follows line low", {7'b0, hl_n}, 8'h00);
        wr(1'b1, 8'h00);
        chk("R9 masked stays high", {7'b0, hl_n}, 8'h01);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h00);
        pin_in = 7'h7E;
        tick(3);
        rd(1'b0, v); chk("R7 line 0 output reads stored", v, 8'h7E);
        pin_in = 7'h7F;
        tick(1);
        wr(1'b1, 8'h00);
        rd(1'b0, v); chk("R8 direction flip meets new level", v, 8'h7F);
    endtask

    task automatic t_idle;
        cs = 1'b0; addr = 1'b0;
        #1;
        chk("R10 unselected read", rdata, 8'h00);
    endtask

    initial begin
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_write_gate();
        t_dir_levels();
        t_merge();
        t_sync();
        t_irq();
        t_collide();
        t_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule